// File: doc/BRIEF.md
# Removable Card Presence Monitor and Reset Control

This block decides whether a removable storage card is seated in its slot by watching two active-low detect contacts. The contacts are brought into the local clock domain through a synchronizer chain. The card counts as present only while both contacts read low together. A change in the synchronized decision must persist for a programmable number of cycles before the block accepts it. Each accepted change, whether insertion or removal, latches a detect event. When software has enabled it, that event drives the block's single interrupt-request line.

Software reaches the block through a small word-addressed register port. A read-only status word shows the two synchronized contact levels and the filtered presence decision. A mode word selects the card access mode and the card type. The same word holds the card reset output, which software raises and lowers itself; about 200 µs is the customary hold time. It also holds a host-enable bit, and clearing then setting that bit resets the transfer logic. An event word carries the sticky detect flag and the interrupt enable.

The block has no streaming data path. Every port is a plain control or status pin. Register writes take effect on the clock edge where `reg_wr` is high, and reads are combinational from `reg_addr`, so the port applies no back-pressure.

Top module: `card_presence_ctrl`

## Requirements
- R1: Status word (address 0) is read-only: bit 0 is the filtered presence, bit 2 is the synchronized level of detect contact 1, bit 3 is the synchronized level of detect contact 2, and all other bits read 0; writes to address 0 change nothing.
- R2: The card is present only when both detect contacts are low at the same time; one contact low with the other high is reported as absent.
- R3: Every accepted change of presence, either insertion or removal, sets the detect-event flag at bit 0 of the event word (address 2).
- R4: The detect-event flag stays set until a write to address 2 with bit 0 equal to 1; a write with bit 0 equal to 0 leaves it unchanged.
- R5: A new presence value is accepted only after the synchronized decision has differed from the current one for STABLE_CYCLES consecutive cycles (default 16); a shorter disturbance changes neither presence nor the event flag.
- R6: Mode word (address 1) bits [1:0] select the access mode, with 0 for memory, 1 for I/O and 2 for true IDE, and drive `card_mode`. A write carrying 3 in that field keeps the previous mode. Bit 2 selects the card type, 0 plain and 1 extended, and drives `card_type`.
- R7: Mode word bit 3 drives `card_rst` directly and holds it for as long as software leaves it set.
- R8: Mode word bit 4 is the host enable: while it is 0 the `xfer_rst` output is high, and while it is 1 `xfer_rst` is low.
- R9: `irq` is high exactly when the detect-event flag is set and the interrupt enable (event word bit 1, read/write) is 1.
- R10: After reset the mode word, event word and presence read 0, `card_rst` and `irq` are low, and `xfer_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det1_n | input | 1 | Detect contact 1, active low, asynchronous |
| det2_n | input | 1 | Detect contact 2, active low, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| card_mode | output | 2 | Selected access mode |
| card_type | output | 1 | Selected card type |
| card_rst | output | 1 | Card reset output |
| xfer_rst | output | 1 | Transfer-logic reset, high while host enable is clear |
| irq | output | 1 | Interrupt request toward the interrupt unit |

## Verification
Some properties are checked on every cycle. The mode field never holds the illegal value 3. Presence never rises unless both contacts were low. Presence stays put whenever the synchronized decision agrees with it. Every accepted change leaves the event flag set, and the flag only falls after a write-one-to-clear. Other behaviour can only be shown by the bench's scenarios, through register reads and output pins: a single contact low is treated as absent, a short disturbance is rejected while a long one is accepted, insertion and removal both raise the interrupt, and a reset bit stays held over time.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  localparam int ADDR_STATUS = 0;
  localparam int ADDR_MODE   = 1;
  localparam int ADDR_EVENT  = 2;

  // status word bit positions
  localparam int ST_PRESENT = 0;
  localparam int ST_DET1    = 2;
  localparam int ST_DET2    = 3;

  // mode word bit positions
  localparam int MD_TYPE  = 2;
  localparam int MD_RST   = 3;
  localparam int MD_HOST  = 4;

  // event word bit positions
  localparam int EV_PEND = 0;
  localparam int EV_EN   = 1;

  typedef enum logic [1:0] {
    ACC_MEM  = 2'd0,
    ACC_IO   = 2'd1,
    ACC_IDE  = 2'd2,
    ACC_RSVD = 2'd3
  } acc_mode_t;
endpackage

// File: rtl/cpd_sync.sv
module cpd_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= RST_VAL;
    else        chain_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= RST_VAL;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/cpd_presence.sv
module cpd_presence #(
  parameter int STABLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic both_low,
  output logic present,
  output logic change
);
  logic present_q;

  if (STABLE_CYCLES <= 1) begin : g_direct
    assign change = (both_low != present_q);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) present_q <= 1'b0;
      else        present_q <= both_low;
    end
  end else begin : g_filter
    localparam int CNT_W = $clog2(STABLE_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_CYCLES - 1);
    logic [CNT_W-1:0] cnt_q;
    logic             differ;

    assign differ = (both_low != present_q);
    assign change = differ && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q     <= '0;
        present_q <= 1'b0;
      end else if (!differ) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        cnt_q     <= '0;
        present_q <= both_low;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end

    // R5: window counter never runs past its last value
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
  end

  assign present = present_q;

  // R2: presence only rises when both contacts were low
  p_rise_needs_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(present_q) |-> $past(both_low));

  // R5: agreement between raw decision and presence freezes presence
  p_hold_when_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (both_low == present_q) |=> $stable(present_q));
endmodule

// File: rtl/cpd_regs.sv
module cpd_regs
  import cpd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              present,
  input  logic              change,
  input  logic [1:0]        det_lvl,
  output acc_mode_t         mode,
  output logic              card_type,
  output logic              card_rst,
  output logic              host_en,
  output logic              evt_pend,
  output logic              irq_en
);
  logic wr_mode, wr_event;
  logic unused_wdata;

  assign wr_mode  = reg_wr && (reg_addr == ADDR_W'(ADDR_MODE));
  assign wr_event = reg_wr && (reg_addr == ADDR_W'(ADDR_EVENT));
  assign unused_wdata = ^reg_wdata[DATA_W-1:5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= ACC_MEM;
      card_type <= 1'b0;
      card_rst  <= 1'b0;
      host_en   <= 1'b0;
    end else if (wr_mode) begin
      if (reg_wdata[1:0] != 2'b11) mode <= acc_mode_t'(reg_wdata[1:0]);
      card_type <= reg_wdata[MD_TYPE];
      card_rst  <= reg_wdata[MD_RST];
      host_en   <= reg_wdata[MD_HOST];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_pend <= 1'b0;
      irq_en   <= 1'b0;
    end else begin
      if (wr_event) irq_en <= reg_wdata[EV_EN];
      // a new event takes priority over a clear in the same cycle
      if (change)                            evt_pend <= 1'b1;
      else if (wr_event && reg_wdata[EV_PEND]) evt_pend <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(ADDR_STATUS): begin
        reg_rdata[ST_PRESENT] = present;
        reg_rdata[ST_DET1]    = det_lvl[0];
        reg_rdata[ST_DET2]    = det_lvl[1];
      end
      ADDR_W'(ADDR_MODE): begin
        reg_rdata[1:0]     = mode;
        reg_rdata[MD_TYPE] = card_type;
        reg_rdata[MD_RST]  = card_rst;
        reg_rdata[MD_HOST] = host_en;
      end
      ADDR_W'(ADDR_EVENT): begin
        reg_rdata[EV_PEND] = evt_pend;
        reg_rdata[EV_EN]   = irq_en;
      end
      default: reg_rdata = '0;
    endcase
  end

  // R6: the reserved access mode never becomes active
  p_mode_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode != ACC_RSVD);

  // R3: an accepted presence change leaves the event flag set
  p_event_on_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    change |=> evt_pend);

  // R4: the flag only falls after a write of one to its bit
  p_clear_only_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(evt_pend) |-> $past(wr_event && reg_wdata[EV_PEND]));
endmodule

// File: rtl/card_presence_ctrl.sv
module card_presence_ctrl
  import cpd_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int STABLE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              det1_n,
  input  logic              det2_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [1:0]        card_mode,
  output logic              card_type,
  output logic              card_rst,
  output logic              xfer_rst,
  output logic              irq
);
  logic [1:0] det_sync;
  logic       both_low, present, change;
  logic       host_en, evt_pend, irq_en;
  acc_mode_t  mode;

  cpd_sync #(
    .WIDTH   (2),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (2'b11)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({det2_n, det1_n}),
    .sync_out (det_sync)
  );

  assign both_low = ~det_sync[0] & ~det_sync[1];

  cpd_presence #(
    .STABLE_CYCLES (STABLE_CYCLES)
  ) u_presence (
    .clk      (clk),
    .rst_n    (rst_n),
    .both_low (both_low),
    .present  (present),
    .change   (change)
  );

  cpd_regs #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .present   (present),
    .change    (change),
    .det_lvl   (det_sync),
    .mode      (mode),
    .card_type (card_type),
    .card_rst  (card_rst),
    .host_en   (host_en),
    .evt_pend  (evt_pend),
    .irq_en    (irq_en)
  );

  assign card_mode = mode;
  assign xfer_rst  = ~host_en;
  assign irq       = evt_pend & irq_en;

  // R2: a present card implies both synchronized contacts were low at acceptance
  p_present_on_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(present) |-> $past(det_sync == 2'b00));
endmodule

// File: tb/card_presence_ctrl_tb_top.sv
`timescale 1ns/1ps
module card_presence_ctrl_tb_top;
  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          det1_n = 1'b1, det2_n = 1'b1;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [1:0]    card_mode;
  logic          card_type, card_rst, xfer_rst, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  card_presence_ctrl #(
    .DATA_W (DW), .ADDR_W (AW), .SYNC_STAGES (2), .STABLE_CYCLES (16)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .det1_n (det1_n), .det2_n (det2_n),
    .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata), .card_mode (card_mode), .card_type (card_type),
    .card_rst (card_rst), .xfer_rst (xfer_rst), .irq (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = AW'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    rd(0, v); chk("R10 status after reset", v, 32'h0000_000C);
    rd(1, v); chk("R10 mode after reset", v, 32'h0);
    rd(2, v); chk("R10 event after reset", v, 32'h0);
    @(negedge clk);
    chk("R10 irq low", irq, 1'b0);
    chk("R10 card_rst low", card_rst, 1'b0);
    chk("R8 xfer_rst high with host disabled", xfer_rst, 1'b1);
  endtask

  task automatic t_status_readonly();
    logic [31:0] v;
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); chk("R1 status ignores writes", v, 32'h0000_000C);
  endtask

  task automatic t_single_contact();
    logic [31:0] v;
    wr(2, 32'h2);
    det1_n = 1'b0;
    wait_cyc(40);
    rd(0, v); chk("R2 one contact low is absent", v, 32'h0000_0008);
    rd(2, v); chk("R2 no event for single contact", v, 32'h2);
  endtask

  task automatic t_glitch();
    logic [31:0] v;
    det2_n = 1'b0;
    wait_cyc(8);
    det2_n = 1'b1;
    wait_cyc(40);
    rd(0, v); chk("R5 short disturbance rejected", v, 32'h0000_0008);
    rd(2, v); chk("R5 no event from disturbance", v, 32'h2);
  endtask

  task automatic t_insert();
    logic [31:0] v;
    det2_n = 1'b0;
    wait_cyc(12);
    rd(0, v); chk("R5 not yet accepted inside window", v, 32'h0);
    wait_cyc(30);
    rd(0, v); chk("R1 R2 both low reads present", v, 32'h0000_0001);
    rd(2, v); chk("R3 insertion sets event", v, 32'h3);
    @(negedge clk); chk("R9 irq on enabled event", irq, 1'b1);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(2, 32'h2);
    rd(2, v); chk("R4 write of zero keeps flag", v, 32'h3);
    wr(2, 32'h3);
    rd(2, v); chk("R4 write of one clears flag", v, 32'h2);
    @(negedge clk); chk("R9 irq drops after clear", irq, 1'b0);
  endtask

  task automatic t_remove();
    logic [31:0] v;
    det1_n = 1'b1;
    wait_cyc(40);
    rd(0, v); chk("R2 removal reads absent", v, 32'h0000_0004);
    rd(2, v); chk("R3 removal sets event", v, 32'h3);
    wr(2, 32'h0);
    rd(2, v); chk("R9 enable cleared, flag kept", v, 32'h1);
    @(negedge clk); chk("R9 irq masked", irq, 1'b0);
    wr(2, 32'h1);
    rd(2, v); chk("R4 flag cleared", v, 32'h0);
  endtask

  task automatic t_mode();
    logic [31:0] v;
    wr(1, 32'h1);
    @(negedge clk); chk("R6 io mode output", card_mode, 2'd1);
    wr(1, 32'h6);
    @(negedge clk); chk("R6 ide mode output", card_mode, 2'd2);
    chk("R6 extended card type", card_type, 1'b1);
    wr(1, 32'h3);
    rd(1, v); chk("R6 reserved mode keeps previous", v, 32'h2);
    chk("R6 plain card type", card_type, 1'b0);
  endtask

  task automatic t_card_reset();
    wr(1, 32'hA);
    @(negedge clk); chk("R7 card_rst set", card_rst, 1'b1);
    wait_cyc(60);
    @(negedge clk); chk("R7 card_rst held", card_rst, 1'b1);
    wr(1, 32'h2);
    @(negedge clk); chk("R7 card_rst released", card_rst, 1'b0);
  endtask

  task automatic t_host_enable();
    wr(1, 32'h12);
    @(negedge clk); chk("R8 host enable releases xfer_rst", xfer_rst, 1'b0);
    wr(1, 32'h02);
    @(negedge clk); chk("R8 host clear asserts xfer_rst", xfer_rst, 1'b1);
    wr(1, 32'h12);
    @(negedge clk); chk("R8 host re-enable", xfer_rst, 1'b0);
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);
    t_reset_state();
    t_status_readonly();
    t_single_contact();
    t_glitch();
    t_insert();
    t_clear();
    t_remove();
    t_mode();
    t_card_reset();
    t_host_enable();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule